// File: doc/BRIEF.md
# Cell Transmit Framer with Timing-Marker Insertion

The framer turns fixed 53-byte cells, read one byte at a time from an upstream cell buffer, into the serial bit stream of a 25.6 Mbps cell link. Ahead of every cell it sends a two-symbol command byte that opens the cell. It scrambles each payload nibble with a keystream from a 10-bit shift-register generator and maps every nibble to a 5-bit line symbol. It then shifts the symbols out one bit per clock and NRZI-codes them. When no cell is ready it sends idle data symbols, so the line always carries valid codes.

An 8 kHz sync input asks for a timing marker. The marker goes out at the next byte boundary and has priority over everything else, including a cell that is half sent. The cell carries on after the marker, and the marker does not advance the scrambler. The cell source chooses, cell by cell, whether the scrambler is re-seeded at the start of the cell. The block emits one line bit per clock, so the same design runs at 25.6 or 51.2 Mbps; only the bit clock that drives it differs.

Top module: `cell_tx_framer`

## Requirements
- R1: While reset is held, `line_out` is 0 and `cell_rd` is 0. After reset the scrambler state is all ones.
- R2: With no cell in progress and no marker waiting, every transmitted byte is the idle byte 0x00, sent unscrambled as two data symbols (11110 11110).
- R3: A byte is sent as two 5-bit symbols, high nibble first, each symbol MSB first. Data symbols for nibbles 0..F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. The escape symbol is 11000. A cell starts only when `cell_avail` is high at a byte boundary. It is then sent as exactly one start command byte followed by its 53 payload bytes. No start command appears inside a cell.
- R4: When `cell_reseed` is high at the start of a cell, the start command is escape,escape. The scrambler is reloaded with all ones before the first payload byte.
- R5: When `cell_reseed` is low, the start command is escape followed by the symbol for 4 (01010), and the scrambler keeps its state.
- R6: A rising edge on `sync_in` produces a marker command byte: escape followed by the symbol for 8 (10010). The first bit of the marker appears on the line at most 11 clock edges after the edge at which the sync pulse is sampled.
- R7: A marker requested during a cell is inserted between two payload bytes. The cell then resumes with unchanged keystream and still delivers all 53 payload bytes in order.
- R8: A sync edge that arrives while a marker is already being sent is held. A second marker follows directly after the first.
- R9: Every 10-bit group on the line decodes to valid symbols. Each payload byte sent equals the source byte XOR 8 keystream bits. Each keystream bit is s[9]^s[6] of the 10-bit state s, and the state then shifts left, taking that bit in at s[0]. The first bit goes in the byte's MSB. The line level toggles for a 1 bit and holds for a 0 bit.
- R10: `cell_rd` pulses exactly once for each payload byte sent: 53 times per cell, never twice in a row. `cell_byte` is taken in the same cycle.
- R11: If a marker is waiting and a cell is ready at the same byte boundary, the marker is sent first and the start command immediately after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_avail | input | 1 | A complete 53-byte cell is buffered upstream |
| cell_reseed | input | 1 | Start the next cell with a scrambler reload |
| cell_byte | input | 8 | Byte at the head of the upstream buffer |
| cell_rd | output | 1 | Consume `cell_byte` this cycle |
| sync_in | input | 1 | 8 kHz timing sync, rising edge requests a marker |
| line_out | output | 1 | NRZI-coded serial line bit |

## Verification
The assertions assume that `sync_in` is a clean level, low during reset, and that its rising edges are far apart compared with a byte time, except where two of them are meant to fall inside one marker. They also assume that `cell_avail` is high only when a whole cell is buffered, and that it stays high until that cell is read. The stimulus raises `cell_avail` only after writing all 53 bytes and lowers it as the buffer drains. Sync pulses are one clock wide and low during reset. They are aligned to the byte grid only where the test needs a particular overlap: two markers back to back, or a marker racing a ready cell.

// File: rtl/cell_tx_framer.sv
module cell_tx_framer #(
  parameter int         CELL_BYTES = 53,
  parameter logic [9:0] SEED       = 10'h3FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_avail,
  input  logic       cell_reseed,
  input  logic [7:0] cell_byte,
  output logic       cell_rd,
  input  logic       sync_in,
  output logic       line_out
);
  localparam int         CW   = $clog2(CELL_BYTES + 1);
  localparam logic [4:0] ESC  = 5'b11000;
  localparam logic [9:0] IDLE = 10'b11110_11110;

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110;  4'h1: enc = 5'b01001;
      4'h2: enc = 5'b10100;  4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010;  4'h5: enc = 5'b01011;
      4'h6: enc = 5'b01110;  4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010;  4'h9: enc = 5'b10011;
      4'hA: enc = 5'b10110;  4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010;  4'hD: enc = 5'b11011;
      4'hE: enc = 5'b11100;  default: enc = 5'b11101;
    endcase
  endfunction

  logic [9:0]    shreg, word_nx, lfsr, lfsr_nx;
  logic [3:0]    bitc;
  logic [CW-1:0] left;
  logic          pend, sync_q;
  logic [7:0]    ks, pay;
  logic          bound, sync_rise, take_mk, take_pay, take_sc;

  assign bound     = (bitc == 4'd9);
  assign sync_rise = sync_in & ~sync_q;
  assign take_mk   = bound & pend;
  assign take_pay  = bound & ~pend & (left != '0);
  assign take_sc   = bound & ~pend & (left == '0) & cell_avail;
  assign cell_rd   = take_pay;
  assign pay       = cell_byte ^ ks;

  always_comb begin
    lfsr_nx = lfsr;
    ks      = '0;
    for (int i = 0; i < 8; i++) begin
      ks      = {ks[6:0], lfsr_nx[9] ^ lfsr_nx[6]};
      lfsr_nx = {lfsr_nx[8:0], ks[0]};
    end
  end

  always_comb begin
    if (take_mk)       word_nx = {ESC, enc(4'h8)};
    else if (take_pay) word_nx = {enc(pay[7:4]), enc(pay[3:0])};
    else if (take_sc)  word_nx = {ESC, cell_reseed ? ESC : enc(4'h4)};
    else               word_nx = IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= IDLE;
      bitc     <= '0;
      line_out <= 1'b0;
      lfsr     <= SEED;
      left     <= '0;
      pend     <= 1'b0;
      sync_q   <= 1'b0;
    end else begin
      sync_q   <= sync_in;
      pend     <= sync_rise | (pend & ~take_mk);
      line_out <= line_out ^ shreg[9];
      shreg    <= bound ? word_nx : {shreg[8:0], 1'b0};
      bitc     <= bound ? 4'd0 : bitc + 4'd1;
      if (take_sc)       left <= CW'(CELL_BYTES);
      else if (take_pay) left <= left - 1'b1;
      if (take_sc && cell_reseed) lfsr <= SEED;
      else if (take_pay)          lfsr <= lfsr_nx;
    end
  end
endmodule

// File: rtl/cell_tx_framer_chk.sv
module cell_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_in,
  input logic cell_rd,
  input logic pend,
  input logic bound,
  input logic idle_slot
);
  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_in) |=> pend);

  // R8
  mk_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_in) && bound && pend) |=> pend);

  // R11
  mk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && pend && idle_slot) |=> idle_slot);

  // R10
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_rd |=> !cell_rd);

  // R10
  rd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_rd |-> (bound && !pend));
endmodule

bind cell_tx_framer cell_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .cell_rd(cell_rd),
  .pend(pend), .bound(bound), .idle_slot(left == '0)
);

// File: tb/cell_tx_framer_tb.sv
module cell_tx_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] ESC = 5'b11000, S4 = 5'b01010, S8 = 5'b10010;

  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0;
  logic cell_rd, line_out, cell_avail, cell_reseed;
  logic [7:0] cell_byte;

  logic [7:0] src [0:1023];
  bit         cell_rs [0:31];
  int wr_ptr = 0, rd_ptr = 0, rd_cnt = 0;
  int total = 0, bad = 0;
  int cyc = 0;
  logic run = 1'b0;

  assign cell_avail  = (wr_ptr - rd_ptr) >= 53;
  assign cell_byte   = src[rd_ptr % 1024];
  assign cell_reseed = cell_rs[(rd_ptr / 53) % 32];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cell_tx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .cell_avail(cell_avail), .cell_reseed(cell_reseed),
    .cell_byte(cell_byte), .cell_rd(cell_rd), .sync_in(sync_in), .line_out(line_out)
  );

  always @(posedge clk) begin
    run <= rst_n;
    if (rst_n) cyc <= cyc + 1;
    if (cell_rd) begin
      rd_ptr <= rd_ptr + 1;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic int nib(input logic [4:0] s);
    case (s)
      5'b11110: return 0;  5'b01001: return 1;  5'b10100: return 2;  5'b10101: return 3;
      5'b01010: return 4;  5'b01011: return 5;  5'b01110: return 6;  5'b01111: return 7;
      5'b10010: return 8;  5'b10011: return 9;  5'b10110: return 10; 5'b10111: return 11;
      5'b11010: return 12; 5'b11011: return 13; 5'b11100: return 14; 5'b11101: return 15;
      default:  return -1;
    endcase
  endfunction

  // line monitor and reference model
  logic prev_line = 1'b0, raw;
  logic [9:0] word = '0, lf = 10'h3FF;
  logic [7:0] b, ks;
  int bitk = 0, wstart = 0, hn, ln, kind, prev_kind = 0;
  bit in_cell = 0;
  int pay_cnt = 0, exp_idx = 0, cells_done = 0, idle_words = 0;
  int markers = 0, mid_mk = 0, last_mk = 0, mk_run = 0, mk_run_max = 0;
  int start_prev = 0, bad_sym = 0;

  always @(negedge clk) if (run) begin
    raw = line_out ^ prev_line;
    prev_line = line_out;
    if (bitk == 0) wstart = cyc;
    word = {word[8:0], raw};
    bitk++;
    if (bitk == 10) begin
      bitk = 0;
      kind = 0;
      hn = nib(word[9:5]);
      ln = nib(word[4:0]);
      if (word[9:5] == ESC) begin
        if (word[4:0] == ESC || word[4:0] == S4) begin
          check(!in_cell, "R3 start command inside cell", int'(in_cell), 0);
          check((word[4:0] == ESC) == cell_rs[cells_done % 32],
                cell_rs[cells_done % 32] ? "R4 reseed start command" : "R5 plain start command",
                int'(word[4:0]), cell_rs[cells_done % 32] ? int'(ESC) : int'(S4));
          if (word[4:0] == ESC) lf = 10'h3FF;
          in_cell = 1;
          pay_cnt = 0;
          start_prev = prev_kind;
          kind = 2;
        end else if (word[4:0] == S8) begin
          markers++;
          last_mk = wstart;
          if (in_cell) mid_mk++;
          mk_run = (prev_kind == 3) ? mk_run + 1 : 1;
          if (mk_run > mk_run_max) mk_run_max = mk_run;
          kind = 3;
        end else bad_sym++;
      end else if (hn < 0 || ln < 0) begin
        bad_sym++;
      end else begin
        b = {hn[3:0], ln[3:0]};
        if (in_cell) begin
          ks = '0;
          for (int i = 0; i < 8; i++) begin
            ks = {ks[6:0], lf[9] ^ lf[6]};
            lf = {lf[8:0], ks[0]};
          end
          check((b ^ ks) == src[exp_idx % 1024], "R3 R9 payload byte",
                int'(b ^ ks), int'(src[exp_idx % 1024]));
          exp_idx++;
          pay_cnt++;
          if (pay_cnt == 53) begin
            in_cell = 0;
            cells_done++;
          end
          kind = 1;
        end else begin
          check(b == 8'h00, "R2 idle byte", int'(b), 0);
          idle_words++;
          kind = 4;
        end
      end
      prev_kind = kind;
    end
  end

  task automatic load_cell(input bit rs, input int seed);
    cell_rs[(wr_ptr / 53) % 32] = rs;
    for (int i = 0; i < 53; i++) src[(wr_ptr + i) % 1024] = 8'((seed * 37 + i * 11) ^ (i << 3));
    wr_ptr += 53;
  endtask

  task automatic wait_cells(input int n);
    int t = 0;
    while (cells_done < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(cells_done >= n, "R3 cell completion", cells_done, n);
  endtask

  task automatic pulse_aligned(output int p1);
    do @(negedge clk); while (cyc % 10 != 0);
    sync_in = 1'b1;
    p1 = cyc + 1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(line_out == 1'b0, "R1 line low in reset", int'(line_out), 0);
    check(cell_rd == 1'b0, "R1 no read in reset", int'(cell_rd), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle;
    repeat (60) @(negedge clk);
    check(idle_words >= 4, "R2 idle words sent", idle_words, 4);
    check(cells_done == 0 && markers == 0, "R2 nothing but idle", cells_done + markers, 0);
  endtask

  task automatic t_two_cells;
    load_cell(1'b1, 1);
    load_cell(1'b0, 2);
    wait_cells(2);
    check(rd_cnt == 106, "R10 reads for two cells", rd_cnt, 106);
  endtask

  task automatic t_marker_idle;
    int p1, m0;
    m0 = markers;
    pulse_aligned(p1);
    repeat (30) @(negedge clk);
    check(markers == m0 + 1, "R6 one marker sent", markers, m0 + 1);
    check(last_mk - p1 <= 11 && last_mk - p1 >= 1, "R6 marker latency", last_mk - p1, 11);
  endtask

  task automatic t_mid_cell;
    int m0, n0, p1;
    m0 = mid_mk;
    n0 = cells_done;
    load_cell(1'b0, 3);
    while (!(in_cell && pay_cnt >= 20)) @(posedge clk);
    @(negedge clk);
    sync_in = 1'b1;
    p1 = cyc + 1;
    @(negedge clk);
    sync_in = 1'b0;
    wait_cells(n0 + 1);
    check(mid_mk == m0 + 1, "R7 marker inside cell", mid_mk, m0 + 1);
    check(last_mk - p1 <= 11, "R6 marker latency mid cell", last_mk - p1, 11);
    check(rd_cnt == 53 * cells_done, "R10 reads after interrupted cell", rd_cnt, 53 * cells_done);
  endtask

  task automatic t_double;
    int p1, p2, m0;
    @(posedge clk);
    mk_run_max = 0;
    m0 = markers;
    pulse_aligned(p1);
    pulse_aligned(p2);
    repeat (40) @(negedge clk);
    check(markers == m0 + 2, "R8 two markers", markers, m0 + 2);
    check(mk_run_max == 2, "R8 markers back to back", mk_run_max, 2);
  endtask

  task automatic t_priority;
    int n0;
    n0 = cells_done;
    do @(negedge clk); while (cyc % 10 != 0);
    load_cell(1'b1, 4);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    wait_cells(n0 + 1);
    check(start_prev == 3, "R11 marker before start command", start_prev, 3);
  endtask

  initial begin
    t_reset;
    t_idle;
    t_two_cells;
    t_marker_idle;
    t_mid_cell;
    t_double;
    t_priority;
    repeat (30) @(negedge clk);
    check(bad_sym == 0, "R9 invalid symbols", bad_sym, 0);
    check(rd_cnt == 53 * cells_done, "R10 total reads", rd_cnt, 53 * cells_done);
    check(in_cell == 0, "R3 no cell left open", int'(in_cell), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule